// File: doc/BRIEF.md
# Serial-programmed glitch-free clock gate

This block lets software stop or restart individual clock outputs one by one, for power management. Programming arrives over a two-wire serial link: a free-running serial clock and a data line that is sampled on each rising edge of that clock. The line idles high. A frame is one low start bit followed by twelve enable bits. Once the twelfth bit arrives, the whole word is copied into the active enable register at once. A bit at 1 lets its output run, and a bit at 0 stops it.

Each of the twelve gated outputs has its own input clock. The enable bit is carried into that clock's domain through a resynchronizer. It is then applied by a register that updates only on the falling edge of that clock. Because of this, an output can start or stop only while it is low, every high pulse it produces is a complete one, and a stopped output sits at logic 0. Two more clocks pass through the block unconditionally. They stand for the outputs that this link cannot stop.

Top module: `serial_clock_gate`

## Requirements
- R1: After reset every enable bit is 1, so all twelve gated outputs run.
- R2: While the receiver waits for a frame, a high level on the data line is ignored and the enables do not change.
- R3: A frame is a 0 start bit followed by 12 data bits, one per rising serial-clock edge. The enables change only when the twelfth data bit is sampled. After eleven data bits the outputs are unchanged.
- R4: A data bit of 1 lets the matching output toggle with its input clock, and a 0 stops it.
- R5: A stopped output is held at logic 0.
- R6: Enable changes take effect only during the output's low phase. Every high pulse on a gated output lasts exactly one full high phase of its input clock.
- R7: The first data bit after the start bit controls output index 0, and the last controls index 11. Indices 0 to 3 are bank A outputs 0 to 3, indices 4 to 7 are bank B outputs 0 to 3, indices 8 to 10 are bank C outputs 1 to 3, and index 11 is the sync output.
- R8: The two free-running outputs copy their input clocks no matter what the enable word holds.
- R9: After the twelfth data bit the receiver returns to waiting, so a start bit on the very next serial edge begins a new frame.
- R10: A committed enable reaches a gated output through a resynchronizer of at least two stages clocked by that output's clock. No output responds within 8 ns of the commit, and every output has responded within four of its own clock periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ser_clk | input | 1 | Free-running serial clock; data sampled on rising edges |
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| ser_din | input | 1 | Serial data line; idles high, low start bit begins a frame |
| clk_in | input | NUM_GATED | Source clocks of the gated outputs |
| clk_out | output | NUM_GATED | Gated clocks, held low while stopped |
| run_clk_in | input | NUM_FREE | Source clocks of the outputs that always run |
| run_clk_out | output | NUM_FREE | Ungated copies of run_clk_in |

## Verification
The new word is committed on the serial edge that samples the twelfth data bit. Each output then needs two rising edges of its own clock and one falling edge before it changes, so the delay is under three of that output's periods. The bench therefore waits 70 ns (four periods of the slowest 17 ns test clock) after a frame before it counts output edges over a window, and it checks separately that no output moves in the first 8 ns after the commit. Pulse widths are measured at every falling edge of each gated output and compared with that clock's exact half period. To hold a half-received frame, the bench parks the serial clock low, which lets it inspect the outputs between the eleventh and twelfth bits.

// File: rtl/sgate_pkg.sv
`timescale 1ns/1ps
package sgate_pkg;
   typedef enum logic {
      RX_HUNT  = 1'b0,
      RX_SHIFT = 1'b1
   } rx_state_e;
endpackage

// File: rtl/sgate_rx.sv
`timescale 1ns/1ps
module sgate_rx #(
   parameter int WORD_W = 12,
   localparam int CNT_W = $clog2(WORD_W)
) (
   input  logic              ser_clk,
   input  logic              rst_n,
   input  logic              ser_din,
   output logic [WORD_W-1:0] en_word
);
   import sgate_pkg::*;

   localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

   rx_state_e         state;
   logic [CNT_W-1:0]  cnt;
   logic [WORD_W-1:0] shreg;
   logic [WORD_W-1:0] next_shreg;

   initial begin
      assert (WORD_W >= 2) else $error("sgate_rx: WORD_W must be at least 2");
   end

   // new bit enters at the top, so the first bit of the frame ends at index 0
   assign next_shreg = {ser_din, shreg[WORD_W-1:1]};

   always_ff @(posedge ser_clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= RX_HUNT;
         cnt     <= '0;
         shreg   <= '1;
         en_word <= '1;
      end else begin
         case (state)
            RX_HUNT: begin
               if (!ser_din) begin
                  state <= RX_SHIFT;
                  cnt   <= '0;
               end
            end
            RX_SHIFT: begin
               shreg <= next_shreg;
               if (cnt == LAST) begin
                  en_word <= next_shreg;
                  state   <= RX_HUNT;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: state <= RX_HUNT;
         endcase
      end
   end

   p_hunt_ignores_high_r2: assert property (@(posedge ser_clk) disable iff (!rst_n)
      (state == RX_HUNT && ser_din) |=> (state == RX_HUNT));

   p_commit_at_end_r3: assert property (@(posedge ser_clk) disable iff (!rst_n)
      !$stable(en_word) |-> $past(state == RX_SHIFT && cnt == LAST));

   p_rearm_after_frame_r9: assert property (@(posedge ser_clk) disable iff (!rst_n)
      (state == RX_SHIFT && cnt == LAST) |=> (state == RX_HUNT));
endmodule

// File: rtl/sgate_sync.sv
`timescale 1ns/1ps
module sgate_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   initial begin
      assert (STAGES >= 2) else $error("sgate_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/sgate_cell.sv
`timescale 1ns/1ps
module sgate_cell #(
   parameter int SYNC_STAGES = 2,
   parameter bit RESYNC      = 1'b1
) (
   input  logic clk_i,
   input  logic rst_n,
   input  logic en_async,
   output logic clk_o
);
   logic sync_en;
   logic gate_en;

   generate
      if (RESYNC) begin : g_resync
         sgate_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
            .clk   (clk_i),
            .rst_n (rst_n),
            .d     (en_async),
            .q     (sync_en)
         );

         p_sync_rise_to_gate_r10: assert property (@(posedge clk_i) disable iff (!rst_n)
            $rose(sync_en) |-> gate_en);

         p_sync_fall_to_gate_r10: assert property (@(posedge clk_i) disable iff (!rst_n)
            $fell(sync_en) |-> !gate_en);
      end else begin : g_direct
         assign sync_en = en_async;
      end
   endgenerate

   // updated on the falling edge: the clock is low whenever gate_en moves
   always_ff @(negedge clk_i or negedge rst_n) begin
      if (!rst_n) gate_en <= 1'b1;
      else        gate_en <= sync_en;
   end

   assign clk_o = clk_i & gate_en;
endmodule

// File: rtl/serial_clock_gate.sv
`timescale 1ns/1ps
module serial_clock_gate #(
   parameter int NUM_GATED   = 12,
   parameter int NUM_FREE    = 2,
   parameter int SYNC_STAGES = 2,
   parameter bit RESYNC      = 1'b1
) (
   input  logic                 ser_clk,
   input  logic                 rst_n,
   input  logic                 ser_din,
   input  logic [NUM_GATED-1:0] clk_in,
   output logic [NUM_GATED-1:0] clk_out,
   input  logic [NUM_FREE-1:0]  run_clk_in,
   output logic [NUM_FREE-1:0]  run_clk_out
);
   logic [NUM_GATED-1:0] en_word;

   initial begin
      assert (NUM_GATED >= 2) else $error("serial_clock_gate: NUM_GATED must be at least 2");
      assert (NUM_FREE >= 1) else $error("serial_clock_gate: NUM_FREE must be at least 1");
      assert (SYNC_STAGES >= 2) else $error("serial_clock_gate: SYNC_STAGES must be at least 2");
   end

   sgate_rx #(.WORD_W(NUM_GATED)) u_rx (
      .ser_clk (ser_clk),
      .rst_n   (rst_n),
      .ser_din (ser_din),
      .en_word (en_word)
   );

   generate
      for (genvar i = 0; i < NUM_GATED; i++) begin : g_cell
         sgate_cell #(.SYNC_STAGES(SYNC_STAGES), .RESYNC(RESYNC)) u_cell (
            .clk_i    (clk_in[i]),
            .rst_n    (rst_n),
            .en_async (en_word[i]),
            .clk_o    (clk_out[i])
         );
      end
   endgenerate

   assign run_clk_out = run_clk_in;
endmodule

// File: tb/tb_serial_clock_gate.sv
`timescale 1ns/1ps
module tb_serial_clock_gate;
   localparam int NG = 12;
   localparam int NF = 2;

   logic          ser_clk = 1'b0;
   logic          ser_run = 1'b1;
   logic          rst_n   = 1'b1;
   logic          ser_din = 1'b1;
   logic [NG-1:0] clk_in;
   logic [NG-1:0] clk_out;
   logic [NF-1:0] run_clk_in;
   logic [NF-1:0] run_clk_out;

   int n_checks = 0;
   int n_fail   = 0;
   int edge_cnt [NG];
   int runt_cnt [NG];
   realtime rise_t [NG];
   int free_cnt [NF];

   serial_clock_gate dut (
      .ser_clk     (ser_clk),
      .rst_n       (rst_n),
      .ser_din     (ser_din),
      .clk_in      (clk_in),
      .clk_out     (clk_out),
      .run_clk_in  (run_clk_in),
      .run_clk_out (run_clk_out)
   );

   // 200 MHz serial clock; parks low when ser_run is cleared
   always begin
      #2.5;
      if (ser_run || ser_clk) ser_clk = ~ser_clk;
   end

   generate
      for (genvar g = 0; g < NG; g++) begin : g_src
         localparam real HALF = (6.0 + g) / 2.0;
         initial begin
            clk_in[g] = 1'b0;
            forever #(HALF) clk_in[g] = ~clk_in[g];
         end
         always @(posedge clk_out[g]) begin
            edge_cnt[g] = edge_cnt[g] + 1;
            rise_t[g]   = $realtime;
         end
         always @(negedge clk_out[g]) begin
            if (($realtime - rise_t[g]) < HALF - 0.001 || ($realtime - rise_t[g]) > HALF + 0.001)
               runt_cnt[g] = runt_cnt[g] + 1;
         end
      end
      for (genvar f = 0; f < NF; f++) begin : g_free
         localparam real FHALF = 5.0 + 2.0 * f;
         initial begin
            run_clk_in[f] = 1'b0;
            forever #(FHALF) run_clk_in[f] = ~run_clk_in[f];
         end
         always @(posedge run_clk_out[f]) free_cnt[f] = free_cnt[f] + 1;
      end
   endgenerate

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
   endtask

   task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic clear_counts();
      for (int i = 0; i < NG; i++) edge_cnt[i] = 0;
      for (int f = 0; f < NF; f++) free_cnt[f] = 0;
   endtask

   task automatic send_frame(input logic [NG-1:0] w);
      @(negedge ser_clk) ser_din = 1'b0;
      for (int k = 0; k < NG; k++) begin
         @(negedge ser_clk) ser_din = w[k];
      end
      @(negedge ser_clk) ser_din = 1'b1;
   endtask

   // settle four periods of the slowest clock, then count edges
   task automatic observe(input logic [NG-1:0] exp, input string req);
      #70;
      clear_counts();
      #120;
      for (int i = 0; i < NG; i++) begin
         if (exp[i])
            check(edge_cnt[i] > 0, req, $sformatf("output %0d runs", i), edge_cnt[i], 1);
         else
            check(edge_cnt[i] == 0 && clk_out[i] == 1'b0, req,
                  $sformatf("output %0d stopped low", i), edge_cnt[i] + int'(clk_out[i]), 0);
      end
   endtask

   task automatic t_reset();
      check(rst_n == 1'b1, "R1", "reset released", int'(rst_n), 1);
      observe(12'hFFF, "R1");
      for (int f = 0; f < NF; f++)
         check(free_cnt[f] > 0, "R8", $sformatf("free output %0d after reset", f), free_cnt[f], 1);
   endtask

   task automatic t_idle_high();
      ser_din = 1'b1;
      repeat (30) @(negedge ser_clk);
      observe(12'hFFF, "R2");
   endtask

   task automatic t_order_and_values();
      send_frame(12'hFFE);
      observe(12'hFFE, "R7");
      send_frame(12'h800);
      observe(12'h800, "R7");
      send_frame(12'h0A5);
      observe(12'h0A5, "R4");
      send_frame(12'h000);
      observe(12'h000, "R5");
      for (int f = 0; f < NF; f++)
         check(free_cnt[f] > 0, "R8", $sformatf("free output %0d with all stopped", f), free_cnt[f], 1);
   endtask

   task automatic t_partial();
      send_frame(12'hFFF);
      observe(12'hFFF, "R3");
      @(negedge ser_clk) ser_din = 1'b0;
      for (int k = 0; k < NG - 1; k++) begin
         @(negedge ser_clk) ser_din = 1'b0;
      end
      @(negedge ser_clk);
      ser_run = 1'b0;
      ser_din = 1'b0;
      observe(12'hFFF, "R3");
      ser_run = 1'b1;
      @(negedge ser_clk) ser_din = 1'b1;
      observe(12'h000, "R3");
   endtask

   task automatic t_back_to_back();
      logic [NG-1:0] w1 = 12'hF0F;
      logic [NG-1:0] w2 = 12'h3C6;
      @(negedge ser_clk) ser_din = 1'b0;
      for (int k = 0; k < NG; k++) begin
         @(negedge ser_clk) ser_din = w1[k];
      end
      @(negedge ser_clk) ser_din = 1'b0;
      for (int k = 0; k < NG; k++) begin
         @(negedge ser_clk) ser_din = w2[k];
      end
      @(negedge ser_clk) ser_din = 1'b1;
      observe(w2, "R9");
   endtask

   task automatic t_latency();
      send_frame(12'h000);
      observe(12'h000, "R10");
      send_frame(12'hFFF);
      clear_counts();
      #8;
      for (int i = 0; i < NG; i++)
         check(edge_cnt[i] == 0, "R10", $sformatf("output %0d quiet just after commit", i), edge_cnt[i], 0);
      #62;
      clear_counts();
      #20;
      for (int i = 0; i < NG; i++)
         check(edge_cnt[i] > 0, "R10", $sformatf("output %0d running after four periods", i), edge_cnt[i], 1);
   endtask

   task automatic t_runts();
      for (int i = 0; i < NG; i++)
         check(runt_cnt[i] == 0, "R6", $sformatf("output %0d short pulses", i), runt_cnt[i], 0);
   endtask

   initial begin
      #100000;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      for (int i = 0; i < NG; i++) begin
         edge_cnt[i] = 0;
         runt_cnt[i] = 0;
         rise_t[i]   = 0.0;
      end
      for (int f = 0; f < NF; f++) free_cnt[f] = 0;
      #1 rst_n = 1'b0;
      repeat (4) @(negedge ser_clk);
      rst_n = 1'b1;
      t_reset();
      t_idle_high();
      t_order_and_values();
      t_partial();
      t_back_to_back();
      t_latency();
      t_runts();
      summary();
      $finish;
   end
endmodule